// File: doc/BRIEF.md
# Critical-Word-First Burst Line Filler

This block refills one cache line from a memory bus that is one double word wide. On a miss it takes the request address and asks the bus for a burst of four beats. The first beat carries the double word that holds the missing address. The later beats wrap around through the remaining double words of the line. Each beat is steered into its own slot of a line buffer. The first beat also goes straight out to the requester in the same cycle, so the stalled load can go on without waiting for the rest of the line.

While a fill is running, the block raises a blocking flag. The surrounding cache uses this flag to refuse all internal accesses. The bus may leave idle cycles between beats; the fill waits through them. When the last beat has been stored, a one-cycle completion pulse is raised with the aligned line address. The whole line is then available in the buffer. Bus arbitration, tag installation and eviction of the old line are handled elsewhere.

Top module: `cwf_line_fill`

## Requirements
- R1: A fill consists of exactly four accepted beats of 64 bits each. After the fourth beat, `line_data` holds all four double words, with slot s in bits [64*s+63 : 64*s].
- R2: The first accepted beat of a fill is written to slot `miss_addr[4:3]`. In that same cycle `fwd_valid` is high and `fwd_data` equals `beat_data`.
- R3: The k-th accepted beat (k = 0..3) is written to slot (`miss_addr[4:3]` + k) mod 4. For example, a miss on index 2 fills slots 2, 3, 0, 1.
- R4: `busy` is high in the cycle a miss is accepted and stays high through the cycle of the fourth beat. It is low in the cycle after the fourth beat.
- R5: During a fill, `bus_req` is high and `bus_addr` equals the miss address with its three low bits cleared.
- R6: `done` is high for exactly one cycle: the cycle after the fourth beat is accepted. In that cycle `done_addr` equals the miss address with its five low bits cleared.
- R7: In a cycle with `beat_valid` low, nothing is written and the beat position holds. The fill resumes with the next beat. A beat presented while no fill is running is ignored and leaves `line_data` unchanged.
- R8: A miss presented while a fill is in progress is ignored. The running fill keeps its bus address, slot order and line address.
- R9: After reset, `busy`, `bus_req`, `wr_en`, `fwd_valid` and `done` are low.
- R10: `fwd_valid` is high only on the first beat of a fill, never on beats two to four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | Miss request strobe |
| miss_addr | input | ADDR_W | Byte address of the missing access |
| busy | output | 1 | Cache blocked for internal accesses |
| bus_req | output | 1 | Burst in progress on the memory bus |
| bus_addr | output | ADDR_W | Double-word address of the critical beat |
| beat_valid | input | 1 | Memory bus delivers a beat this cycle |
| beat_data | input | BEAT_W | Data of the current beat |
| wr_en | output | 1 | Beat written into the line buffer this cycle |
| wr_slot | output | log2(BEATS) | Slot written this cycle |
| wr_data | output | BEAT_W | Data written this cycle |
| fwd_valid | output | 1 | Critical double word forwarded this cycle |
| fwd_data | output | BEAT_W | Forwarded critical double word |
| line_data | output | BEAT_W*BEATS | Line buffer contents, slot 0 in the low bits |
| done | output | 1 | One-cycle fill completion pulse |
| done_addr | output | ADDR_W | Aligned address of the completed line |

## Verification
Fills are started from each of the four double-word positions. This separates a correct wrap-around order from one that always starts at slot 0 or that wraps wrongly. Some fills have idle bus cycles placed before different beats. These cycles show whether the beat position and the blocking flag hold through a gap, or whether the fill advances or ends early. Other fills have a rival miss injected during a gap, which exposes any fill that a second request could restart or redirect. A beat sent while idle checks that an unsolicited beat corrupts nothing.

// File: rtl/lfill_pkg.sv
package lfill_pkg;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_FILL = 1'b1
    } fill_phase_e;

    parameter int unsigned DEF_ADDR_W = 32;
    parameter int unsigned DEF_BEAT_W = 64;
    parameter int unsigned DEF_BEATS  = 4;

endpackage

// File: rtl/lfill_seq.sv
module lfill_seq
    import lfill_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned OFS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              beat_valid,
    output logic              busy,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              take_beat,
    output logic              first_beat,
    output logic [IDX_W-1:0]  beat_pos,
    output logic [IDX_W-1:0]  crit_idx,
    output logic              done,
    output logic [ADDR_W-1:0] done_addr
);
    localparam int unsigned LINE_OFS = OFS_W + IDX_W;

    typedef struct packed {
        fill_phase_e       phase;
        logic [IDX_W-1:0]  cnt;
        logic [IDX_W-1:0]  crit;
        logic [ADDR_W-1:0] dw_addr;
        logic [ADDR_W-1:0] line_addr;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;
    logic start;
    logic last;

    always_comb begin
        start     = (s_q.phase == PH_IDLE) && miss_valid;
        take_beat = (s_q.phase == PH_FILL) && beat_valid;
        last      = take_beat && (s_q.cnt == {IDX_W{1'b1}});

        s_d      = s_q;
        s_d.done = 1'b0;
        if (start) begin
            s_d.phase     = PH_FILL;
            s_d.cnt       = '0;
            s_d.crit      = miss_addr[OFS_W +: IDX_W];
            s_d.dw_addr   = {miss_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
            s_d.line_addr = {miss_addr[ADDR_W-1:LINE_OFS], {LINE_OFS{1'b0}}};
        end else if (take_beat) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (last) begin
                s_d.phase = PH_IDLE;
                s_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, crit: '0,
                     dw_addr: '0, line_addr: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy       = (s_q.phase == PH_FILL) || start;
    assign bus_req    = (s_q.phase == PH_FILL);
    assign bus_addr   = s_q.dw_addr;
    assign first_beat = take_beat && (s_q.cnt == '0);
    assign beat_pos   = s_q.cnt;
    assign crit_idx   = s_q.crit;
    assign done       = s_q.done;
    assign done_addr  = s_q.line_addr;

endmodule

// File: rtl/lfill_slot_map.sv
module lfill_slot_map #(
    parameter int unsigned BEATS = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic             take_beat,
    input  logic [IDX_W-1:0] crit_idx,
    input  logic [IDX_W-1:0] beat_pos,
    output logic [IDX_W-1:0] slot,
    output logic [BEATS-1:0] slot_sel
);
    // Wrap-around ordering: the index width truncates the sum modulo BEATS.
    assign slot = crit_idx + beat_pos;

    for (genvar g = 0; g < BEATS; g++) begin : g_sel
        assign slot_sel[g] = take_beat && (slot == IDX_W'(g));
    end

endmodule

// File: rtl/lfill_line_buf.sv
module lfill_line_buf #(
    parameter int unsigned BEATS  = 4,
    parameter int unsigned BEAT_W = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [BEATS-1:0]        slot_sel,
    input  logic [BEAT_W-1:0]       wr_data,
    output logic [BEAT_W*BEATS-1:0] line_data
);
    for (genvar g = 0; g < BEATS; g++) begin : g_slot
        logic [BEAT_W-1:0] dw_d, dw_q;

        always_comb begin
            dw_d = dw_q;
            if (slot_sel[g]) dw_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dw_q <= '0;
            else        dw_q <= dw_d;
        end

        assign line_data[g*BEAT_W +: BEAT_W] = dw_q;
    end

endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill
    import lfill_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned BEAT_W = DEF_BEAT_W,
    parameter int unsigned BEATS  = DEF_BEATS,
    localparam int unsigned IDX_W = $clog2(BEATS),
    localparam int unsigned OFS_W = $clog2(BEAT_W / 8)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    miss_valid,
    input  logic [ADDR_W-1:0]       miss_addr,
    output logic                    busy,
    output logic                    bus_req,
    output logic [ADDR_W-1:0]       bus_addr,
    input  logic                    beat_valid,
    input  logic [BEAT_W-1:0]       beat_data,
    output logic                    wr_en,
    output logic [IDX_W-1:0]        wr_slot,
    output logic [BEAT_W-1:0]       wr_data,
    output logic                    fwd_valid,
    output logic [BEAT_W-1:0]       fwd_data,
    output logic [BEAT_W*BEATS-1:0] line_data,
    output logic                    done,
    output logic [ADDR_W-1:0]       done_addr
);
    logic             take_beat;
    logic             first_beat;
    logic [IDX_W-1:0] beat_pos;
    logic [IDX_W-1:0] crit_idx;
    logic [BEATS-1:0] slot_sel;

    lfill_seq #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .OFS_W  (OFS_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_valid (miss_valid),
        .miss_addr  (miss_addr),
        .beat_valid (beat_valid),
        .busy       (busy),
        .bus_req    (bus_req),
        .bus_addr   (bus_addr),
        .take_beat  (take_beat),
        .first_beat (first_beat),
        .beat_pos   (beat_pos),
        .crit_idx   (crit_idx),
        .done       (done),
        .done_addr  (done_addr)
    );

    lfill_slot_map #(
        .BEATS (BEATS),
        .IDX_W (IDX_W)
    ) u_map (
        .take_beat (take_beat),
        .crit_idx  (crit_idx),
        .beat_pos  (beat_pos),
        .slot      (wr_slot),
        .slot_sel  (slot_sel)
    );

    lfill_line_buf #(
        .BEATS  (BEATS),
        .BEAT_W (BEAT_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_sel  (slot_sel),
        .wr_data   (beat_data),
        .line_data (line_data)
    );

    assign wr_en     = take_beat;
    assign wr_data   = beat_data;
    assign fwd_valid = first_beat;
    assign fwd_data  = beat_data;

endmodule

// File: rtl/cwf_line_fill_chk.sv
module cwf_line_fill_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned BEAT_W = 64,
    parameter int unsigned BEATS  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              busy,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              beat_valid,
    input logic              wr_en,
    input logic              fwd_valid,
    input logic [BEAT_W-1:0] fwd_data,
    input logic [BEAT_W-1:0] wr_data,
    input logic              done
);
    localparam int unsigned CW = $clog2(BEATS) + 2;
    logic [CW-1:0] writes;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         writes <= '0;
        else if (fwd_valid) writes <= CW'(1);
        else if (wr_en)     writes <= writes + 1'b1;
    end

    // R1
    beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (writes == CW'(BEATS)));

    // R2
    fwd_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (wr_en && fwd_data == wr_data));

    // R4
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_req);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |-> !wr_en);

    // R8
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req)) |-> $stable(bus_addr));

    // R4
    write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    // R8
    miss_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && miss_valid && !done) |=> bus_req || done);

endmodule

bind cwf_line_fill cwf_line_fill_chk #(
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W),
    .BEATS  (BEATS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .busy       (busy),
    .bus_req    (bus_req),
    .bus_addr   (bus_addr),
    .beat_valid (beat_valid),
    .wr_en      (wr_en),
    .fwd_valid  (fwd_valid),
    .fwd_data   (fwd_data),
    .wr_data    (wr_data),
    .done       (done)
);

// File: tb/cwf_line_fill_test.sv
module cwf_line_fill_test;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [31:0]   miss_addr = '0;
    logic          busy, bus_req;
    logic [31:0]   bus_addr;
    logic          beat_valid = 1'b0;
    logic [63:0]   beat_data = '0;
    logic          wr_en;
    logic [1:0]    wr_slot;
    logic [63:0]   wr_data;
    logic          fwd_valid;
    logic [63:0]   fwd_data;
    logic [255:0]  line_data;
    logic          done;
    logic [31:0]   done_addr;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cwf_line_fill uut (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
        .busy(busy), .bus_req(bus_req), .bus_addr(bus_addr),
        .beat_valid(beat_valid), .beat_data(beat_data),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .line_data(line_data),
        .done(done), .done_addr(done_addr)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [3:0]  gaps;
        logic        intrude;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t TBL [NV] = '{
        '{addr: 32'h0000_1000, gaps: 4'b0000, intrude: 1'b0},
        '{addr: 32'h0000_2048, gaps: 4'b0000, intrude: 1'b0},
        '{addr: 32'h0000_3F54, gaps: 4'b0100, intrude: 1'b0},
        '{addr: 32'h1234_5678, gaps: 4'b1010, intrude: 1'b1},
        '{addr: 32'hFFFF_FFE9, gaps: 4'b0001, intrude: 1'b1},
        '{addr: 32'h0000_0018, gaps: 4'b1111, intrude: 1'b0}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] beat_val(input logic [31:0] a, input int n, input int k);
        return {a, 8'(n), 8'(k), 16'hC0DE};
    endfunction

    task automatic run_fill(input logic [31:0] a, input logic [3:0] gaps,
                            input logic intrude, input int n);
        logic [1:0] crit;
        logic [255:0] exp_line;
        crit = a[4:3];
        @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = a;
        #2;
        check(busy == 1'b1, "R4", "busy on accept", 256'(busy), 256'(1));
        @(negedge clk);
        miss_valid = 1'b0;
        #2;
        check(bus_req == 1'b1, "R5", "bus_req", 256'(bus_req), 256'(1));
        check(bus_addr == {a[31:3], 3'b000}, "R5", "bus_addr", 256'(bus_addr),
              256'({a[31:3], 3'b000}));
        for (int k = 0; k < 4; k++) begin
            if (gaps[k]) begin
                beat_valid = 1'b0;
                if (intrude) begin
                    miss_valid = 1'b1;
                    miss_addr  = ~a;
                end
                #1;
                check(wr_en == 1'b0, "R7", "write in gap", 256'(wr_en), 256'(0));
                check(busy == 1'b1, "R4", "busy in gap", 256'(busy), 256'(1));
                @(negedge clk);
                miss_valid = 1'b0;
                if (intrude) begin
                    #1;
                    check(bus_addr == {a[31:3], 3'b000}, "R8", "bus_addr after rival miss",
                          256'(bus_addr), 256'({a[31:3], 3'b000}));
                end
            end
            beat_valid = 1'b1;
            beat_data  = beat_val(a, n, k);
            #2;
            check(wr_en == 1'b1, "R1", "beat accepted", 256'(wr_en), 256'(1));
            check(wr_slot == 2'(crit + k), "R3", "slot order", 256'(wr_slot),
                  256'(2'(crit + k)));
            check(fwd_valid == (k == 0), "R10", "fwd only first", 256'(fwd_valid),
                  256'(k == 0));
            if (k == 0)
                check(fwd_data == beat_val(a, n, 0), "R2", "forwarded data",
                      256'(fwd_data), 256'(beat_val(a, n, 0)));
            check(done == 1'b0, "R6", "no early done", 256'(done), 256'(0));
            check(busy == 1'b1, "R4", "busy on beat", 256'(busy), 256'(1));
            @(negedge clk);
        end
        beat_valid = 1'b0;
        #2;
        check(busy == 1'b0, "R4", "busy released", 256'(busy), 256'(0));
        check(done == 1'b1, "R6", "done pulse", 256'(done), 256'(1));
        check(done_addr == {a[31:5], 5'b0}, "R6", "done_addr", 256'(done_addr),
              256'({a[31:5], 5'b0}));
        for (int s = 0; s < 4; s++)
            exp_line[64*s +: 64] = beat_val(a, n, int'(2'(s - crit)));
        check(line_data == exp_line, "R1", "line contents", line_data, exp_line);
        @(negedge clk);
        #2;
        check(done == 1'b0, "R6", "done one cycle", 256'(done), 256'(0));
    endtask

    initial begin
        logic [255:0] held;
        #2;
        check(busy == 0 && bus_req == 0 && wr_en == 0 && fwd_valid == 0 && done == 0,
              "R9", "reset outputs",
              256'({busy, bus_req, wr_en, fwd_valid, done}), 256'(0));
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++)
            run_fill(TBL[i].addr, TBL[i].gaps, TBL[i].intrude, i);
        // R7: a beat while idle is not stored
        held = line_data;
        @(negedge clk);
        beat_valid = 1'b1;
        beat_data  = 64'hDEAD_BEEF_0BAD_F00D;
        #2;
        check(wr_en == 1'b0, "R7", "idle beat write", 256'(wr_en), 256'(0));
        @(negedge clk);
        beat_valid = 1'b0;
        #2;
        check(line_data == held, "R7", "idle beat ignored", line_data, held);
        check(busy == 1'b0, "R7", "idle beat no busy", 256'(busy), 256'(0));
        // R3: miss on index 2 fills 2,3,0,1
        run_fill(32'h0000_0510, 4'b0000, 1'b0, 9);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule